// File: doc/BRIEF.md
# Energy-to-Frequency Pulse Generator

This block converts an energy value, delivered once per accumulation interval, into a train of active-low pulses on one pin. The average pulse frequency is proportional to that value. On every sample tick the value is scaled by a rate multiplier and a speed factor. The result is added into a 48-bit phase accumulator, and a carry out of the accumulator requests one pulse. Because the fraction left in the accumulator is kept from tick to tick and from interval to interval, timing error never exceeds one tick and does not build up over time.

The upstream logic writes the value for the next interval into a pending register at any time. An interval-start strobe moves the pending value into the generator. If an interval passes without a write and the error mask is set, a missing-data flag is raised. Pulse width follows the measured period and gives about 50% duty cycle, up to a programmable cap. Requests that arrive faster than the generator can serve them are queued one deep. Any further requests are dropped, so the output saturates at one pulse every two ticks and never wraps.

Top module: `energy_pulse_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first pulse starts, `pulse_no` equals `init_lvl_i`. `miss_err_o` resets to 0.
- R2: On each cycle with `tick_i` high, the accumulator adds `inc = S(mag*rate_i + floor(mag*rate_i/2))`, where `mag` is the active value. The 48-bit accumulator wraps, and a carry out of bit 47 requests one pulse. The speed select `speed_i` sets S: 2'b00 shifts left by 2, 2'b01 shifts left by 6, 2'b10 shifts right by 4, and 2'b11 applies no shift.
- R3: When `sgn_i` is 1, an active value with bit 31 set counts as zero. When `sgn_i` is 0, all 32 bits are an unsigned magnitude.
- R4: A value written with `val_we_i` becomes active only at the next `intv_start_i`. Loading a new value leaves the accumulator contents unchanged.
- R5: A started pulse stays low for `min(max(floor(g/2),1), 2*width_i+1)` ticks. Here g is the number of ticks from the previous request to this one, counting the current tick and saturating at 65535. The first request after reset uses g = 65535.
- R6: A request that arrives while the pin is low is held in a one-entry queue. Further requests are dropped. A pulse starts only on a tick where the pin is high, so there are at least two ticks between pulse starts.
- R7: At each `intv_start_i`, `miss_err_o` becomes `err_mask_i` AND (no write since the previous start). A write in the same cycle as a start counts toward the new interval. At other times `miss_err_o` holds its value.
- R8: Once the first pulse has started, the pin idles high regardless of `init_lvl_i`.
- R9: Without `tick_i`, the accumulator, queue and pin state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-tick enable, one cycle per frame |
| intv_start_i | input | 1 | Accumulation interval start strobe |
| val_i | input | 32 | Energy value for the next interval |
| val_we_i | input | 1 | Write strobe for `val_i` |
| sgn_i | input | 1 | Treat the value as two's complement |
| rate_i | input | 16 | Rate multiplier |
| speed_i | input | 2 | Speed factor select |
| width_i | input | 8 | Pulse-width cap register |
| init_lvl_i | input | 1 | Pin level before the first pulse |
| err_mask_i | input | 1 | Enables the missing-data flag |
| pulse_no | output | 1 | Pulse output, active low |
| miss_err_o | output | 1 | Missing-data flag |

## Verification
A behavioural model, built on integers and a queue, follows every clock while the stimulus covers several conditions. A moderate rate with each of the four speed selects checks the carry arithmetic and the fraction carried between pulses. An all-ones value at the fastest setting separates correct saturation at a two-tick period from wrapping or lost queue entries. A negative value under both sign modes separates the magnitude rules. Further cases check that a deferred write does not change the rate before its interval starts, and that the low time follows the width cap when the cap is small and the period when the cap is large. Skipped writes under both mask settings, and a stretch with the tick held off, cover the error flag and the frozen state.

// File: rtl/epg_pkg.sv
package epg_pkg;
  typedef enum logic [1:0] {
    SPD_SHL2 = 2'b00,
    SPD_SHL6 = 2'b01,
    SPD_SHR4 = 2'b10,
    SPD_UNIT = 2'b11
  } speed_e;
endpackage

// File: rtl/epg_load_ctrl.sv
module epg_load_ctrl #(
  parameter int VAL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             intv_start_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic             val_we_i,
  input  logic             err_mask_i,
  output logic [VAL_W-1:0] act_o,
  output logic             err_o
);
  logic [VAL_W-1:0] pend_q, act_q;
  logic             seen_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (val_we_i) pend_q <= val_i;
      if (intv_start_i) begin
        act_q  <= pend_q;
        err_q  <= err_mask_i & ~seen_q;
        seen_q <= val_we_i;
      end else if (val_we_i) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;

  assert_err_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !intv_start_i |=> $stable(err_q));
  assert_act_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !intv_start_i |=> $stable(act_q));
endmodule

// File: rtl/epg_rate_scaler.sv
module epg_rate_scaler #(
  parameter int VAL_W  = 32,
  parameter int RATE_W = 16,
  parameter int INC_W  = VAL_W + RATE_W + 7
) (
  input  logic [VAL_W-1:0]  val_i,
  input  logic              sgn_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [1:0]        spd_i,
  output logic [INC_W-1:0]  inc_o
);
  import epg_pkg::*;
  localparam int PROD_W = VAL_W + RATE_W;

  logic [VAL_W-1:0]  mag;
  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   base;
  speed_e            spd;

  assign spd  = speed_e'(spd_i);
  assign mag  = (sgn_i && val_i[VAL_W-1]) ? '0 : val_i;
  assign prod = PROD_W'(mag) * PROD_W'(rate_i);
  // x1.5 before the power-of-two shift
  assign base = {1'b0, prod} + {2'b00, prod[PROD_W-1:1]};

  always_comb begin
    unique case (spd)
      SPD_SHL2: inc_o = INC_W'(base) << 2;
      SPD_SHL6: inc_o = INC_W'(base) << 6;
      SPD_SHR4: inc_o = INC_W'(base >> 4);
      default:  inc_o = INC_W'(base);
    endcase
  end
endmodule

// File: rtl/epg_phase_acc.sv
module epg_phase_acc #(
  parameter int ACC_W = 48,
  parameter int INC_W = 55,
  parameter int GAP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [INC_W-1:0] inc_i,
  output logic             req_o,
  output logic [GAP_W-1:0] gap_o
);
  localparam int SUM_W = INC_W + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [ACC_W-1:0] acc_q;
  logic [GAP_W-1:0] gap_q, gap_nx;
  logic [SUM_W-1:0] sum;
  logic             carry;

  assign sum    = {{(SUM_W-ACC_W){1'b0}}, acc_q} + {1'b0, inc_i};
  assign carry  = |sum[SUM_W-1:ACC_W];
  assign gap_nx = (gap_q == GAP_MAX) ? GAP_MAX : gap_q + 1'b1;
  assign req_o  = tick_i & carry;
  assign gap_o  = gap_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      gap_q <= GAP_MAX;
    end else if (tick_i) begin
      acc_q <= sum[ACC_W-1:0];
      gap_q <= carry ? '0 : gap_nx;
    end
  end

  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(acc_q) && $stable(gap_q));
  assert_no_carry_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !carry) |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/epg_pulse_shaper.sv
module epg_pulse_shaper #(
  parameter int GAP_W = 16,
  parameter int WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [WID_W-1:0] width_i,
  input  logic             init_lvl_i,
  output logic             pulse_no
);
  localparam int LEN_W = GAP_W;

  logic [LEN_W-1:0] half, lo, cap, len;
  logic [LEN_W-1:0] low_cnt_q, q_len_q;
  logic             q_vld_q, started_q, busy, start;

  assign half = gap_i >> 1;
  assign lo   = (half == '0) ? LEN_W'(1) : half;
  assign cap  = LEN_W'({width_i, 1'b1});
  assign len  = (lo < cap) ? lo : cap;
  assign busy = (low_cnt_q != '0);
  assign start = tick_i && !busy && (q_vld_q || req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      q_len_q   <= '0;
      q_vld_q   <= 1'b0;
      started_q <= 1'b0;
    end else if (tick_i) begin
      if (!busy) begin
        if (q_vld_q) begin
          low_cnt_q <= q_len_q;
          started_q <= 1'b1;
          q_vld_q   <= req_i;
          if (req_i) q_len_q <= len;
        end else if (req_i) begin
          low_cnt_q <= len;
          started_q <= 1'b1;
        end
      end else begin
        low_cnt_q <= low_cnt_q - 1'b1;
        if (req_i && !q_vld_q) begin
          q_vld_q <= 1'b1;
          q_len_q <= len;
        end
      end
    end
  end

  assign pulse_no = started_q ? !busy : init_lvl_i;

  assert_high_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && low_cnt_q == LEN_W'(1)) |=> !busy);
  assert_len_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (low_cnt_q >= LEN_W'(1)) && (low_cnt_q <= LEN_W'({$past(width_i), 1'b1})));
  assert_idle_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !busy) |-> pulse_no);
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int VAL_W  = 32,
  parameter int RATE_W = 16,
  parameter int ACC_W  = 48,
  parameter int GAP_W  = 16,
  parameter int WID_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              intv_start_i,
  input  logic [VAL_W-1:0]  val_i,
  input  logic              val_we_i,
  input  logic              sgn_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [1:0]        speed_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic              init_lvl_i,
  input  logic              err_mask_i,
  output logic              pulse_no,
  output logic              miss_err_o
);
  localparam int INC_W = VAL_W + RATE_W + 7;

  logic [VAL_W-1:0] act;
  logic [INC_W-1:0] inc;
  logic             req;
  logic [GAP_W-1:0] gap;

  epg_load_ctrl #(.VAL_W(VAL_W)) u_load (
    .clk_i, .rst_ni, .intv_start_i, .val_i, .val_we_i, .err_mask_i,
    .act_o(act), .err_o(miss_err_o)
  );

  epg_rate_scaler #(.VAL_W(VAL_W), .RATE_W(RATE_W), .INC_W(INC_W)) u_scale (
    .val_i(act), .sgn_i, .rate_i, .spd_i(speed_i), .inc_o(inc)
  );

  epg_phase_acc #(.ACC_W(ACC_W), .INC_W(INC_W), .GAP_W(GAP_W)) u_acc (
    .clk_i, .rst_ni, .tick_i, .inc_i(inc), .req_o(req), .gap_o(gap)
  );

  epg_pulse_shaper #(.GAP_W(GAP_W), .WID_W(WID_W)) u_shape (
    .clk_i, .rst_ni, .tick_i, .req_i(req), .gap_i(gap), .width_i,
    .init_lvl_i, .pulse_no
  );
endmodule

// File: tb/energy_pulse_gen_tb.sv
module energy_pulse_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 0, rst_n = 0;
  logic tick = 0, intv = 0, we = 0, sgn = 0, init_lvl = 0, mask = 1;
  logic [31:0] val = 0;
  logic [15:0] rate = 0;
  logic [1:0]  spd = 2'b11;
  logic [7:0]  width = 0;
  logic pin, err;

  int n_run = 0, n_fail = 0, falls = 0;
  bit tick_run = 0;
  int tdiv = 0;
  logic pin_prev = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  energy_pulse_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .intv_start_i(intv),
    .val_i(val), .val_we_i(we), .sgn_i(sgn), .rate_i(rate), .speed_i(spd),
    .width_i(width), .init_lvl_i(init_lvl), .err_mask_i(mask),
    .pulse_no(pin), .miss_err_o(err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_acc;
  int m_gap, m_rem;
  int m_q[$];
  bit m_started, m_seen, m_err;
  logic [31:0] m_act, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_gap = 65535; m_rem = 0; m_q.delete();
      m_started = 0; m_seen = 0; m_err = 0; m_act = 0; m_pend = 0;
    end else begin
      if (tick) begin
        logic [63:0] mag, prod, base, inc, s;
        bit r;
        int g, lo, cap, len;
        mag  = (sgn && m_act[31]) ? 64'd0 : {32'd0, m_act};
        prod = mag * {48'd0, rate};
        base = prod + (prod >> 1);
        case (spd)
          2'b00: inc = base << 2;
          2'b01: inc = base << 6;
          2'b10: inc = base >> 4;
          default: inc = base;
        endcase
        s = m_acc + inc;
        r = (s >= 64'h0001_0000_0000_0000);
        m_acc = s & 64'h0000_FFFF_FFFF_FFFF;
        g = (m_gap >= 65535) ? 65535 : m_gap + 1;
        m_gap = r ? 0 : g;
        lo  = (g / 2 < 1) ? 1 : g / 2;
        cap = 2 * int'(width) + 1;
        len = (lo < cap) ? lo : cap;
        if (m_rem == 0) begin
          if (m_q.size() > 0) begin
            m_rem = m_q.pop_front(); m_started = 1;
            if (r) m_q.push_back(len);
          end else if (r) begin
            m_rem = len; m_started = 1;
          end
        end else begin
          m_rem--;
          if (r && m_q.size() == 0) m_q.push_back(len);
        end
      end
      if (intv) begin
        m_err = mask && !m_seen; m_act = m_pend; m_seen = we;
      end else if (we) m_seen = 1;
      if (we) m_pend = val;
    end
    #2;
    begin
      logic exp_pin;
      exp_pin = m_started ? (m_rem == 0) : init_lvl;
      check(pin === exp_pin, m_started ? "R2" : "R1", pin, exp_pin);
      check(err === m_err, "R7", err, m_err);
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin tdiv = 0; tick = 0; end
    else begin
      tdiv++;
      tick = tick_run && (tdiv % TICK_DIV == 0);
    end
    if (pin_prev === 1'b1 && pin === 1'b0) falls++;
    pin_prev = pin;
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [31:0] v);
    @(negedge clk); val = v; we = 1;
    @(negedge clk); we = 0;
  endtask
  task automatic start_intv();
    @(negedge clk); intv = 1;
    @(negedge clk); intv = 0;
  endtask
  task automatic load(input logic [31:0] v);
    wr(v); start_intv();
  endtask
  task automatic low_len(output int n);
    int t = 0;
    n = 0;
    while (!(pin_prev === 1'b1 && pin === 1'b0) && t < 2000) begin @(negedge clk); t++; end
    // the negedge that saw the fall is the first low sample
    n = 1;
    @(negedge clk);
    while (pin === 1'b0 && n < 2000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    clocks(3);
    check(pin === 1'b0, "R1", pin, 0);
    check(err === 1'b0, "R1", err, 0);
    rst_n = 1;
    clocks(3);
    check(pin === 1'b0, "R1", pin, 0);
    tick_run = 1;
    // R7: no write in first interval with mask set
    start_intv(); clocks(1);
    check(err === 1'b1, "R7", err, 1);

    // moderate rate, width cap 2 -> low 5 ticks
    rate = 16'd4096; spd = 2'b11; width = 8'd2;
    load(32'h8000_0000); clocks(1);
    check(err === 1'b0, "R7", err, 0);
    low_len(n);
    check(n == 5 * TICK_DIV, "R5", n, 5 * TICK_DIV);
    clocks(2);
    check(pin === 1'b1, "R8", pin, 1);

    // large cap: low time follows half the period
    width = 8'd255;
    clocks(200);
    low_len(n);
    check(n == 40 || n == 44, "R5", n, 40);

    // each speed select
    for (int k = 0; k < 4; k++) begin
      spd = 2'(k);
      load(32'h0123_4567 + 32'(k) * 32'h1111_0000);
      clocks(300);
    end

    // saturation: one pulse per two ticks
    spd = 2'b01; rate = 16'hFFFF; width = 8'd0;
    load(32'hFFFF_FFFF);
    clocks(40);
    falls = 0;
    clocks(200 * TICK_DIV);
    check(falls >= 99 && falls <= 101, "R6", falls, 100);

    // R3 signed vs unsigned
    spd = 2'b11; rate = 16'd4096; width = 8'd3;
    sgn = 1; load(32'h8000_0000);
    clocks(80); falls = 0; clocks(400);
    check(falls == 0, "R3", falls, 0);
    sgn = 0; start_intv();
    falls = 0; clocks(400);
    check(falls > 0, "R3", falls, 1);

    // R4: write zero but no start -> old value still pulses
    wr(32'h0);
    falls = 0; clocks(400);
    check(falls > 0, "R4", falls, 1);
    start_intv(); clocks(80);
    falls = 0; clocks(400);
    check(falls == 0, "R4", falls, 0);
    check(pin === 1'b1, "R8", pin, 1);

    // R9: tick held off
    load(32'hFFFF_0000);
    tick_run = 0;
    falls = 0; clocks(400);
    check(falls == 0, "R9", falls, 0);
    tick_run = 1;
    falls = 0; clocks(400);
    check(falls > 0, "R9", falls, 1);

    // R7 mask cleared: skipped write gives no flag
    mask = 0; start_intv(); clocks(1);
    check(err === 1'b0, "R7", err, 0);
    mask = 1; start_intv(); clocks(1);
    check(err === 1'b1, "R7", err, 1);
    clocks(20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule